// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches every pin of one GPIO bank and turns pin activity into interrupt status. Each pin carries three control bits held in bank-wide registers: a sense bit (edge or level), a both-edges bit, and a polarity bit. Together they give five trigger modes: rising edge, falling edge, any edge, high level and low level. Pin levels enter through a two-flop synchronizer. Edges are found by comparing the newest synchronized sample with the one before it.

Edge events are latched in a raw status register until software clears them. Clearing is done by writing ones to a clear address. Level-mode status bits simply follow the pin condition. A masked status is the raw status gated by a per-pin enable register. The single bank interrupt line is high whenever any masked bit is set.

Software uses a small word-wide register port with a 3-bit address: write strobe, address and write data, plus a combinational read data output.

Top module: `gpio_irq_detect`

## Requirements
- R1: The sense register (address 0) selects per pin: bit 0 = edge detection, bit 1 = level detection.
- R2: In edge mode, a both-edges register (address 1) bit of 1 makes that pin set its status on rising and on falling edges, whatever its polarity bit.
- R3: In edge mode with the both-edges bit at 0, a polarity register (address 2) bit of 1 selects rising edges and 0 selects falling edges; edge status stays set until cleared.
- R4: In level mode, the status bit is 1 while the pin is high (polarity 1) or low (polarity 0), and follows the pin; a clear write does not hold it low.
- R5: Raw status (read-only, address 4) shows every pin's detected interrupt regardless of the enable register (address 3).
- R6: Masked status (read-only, address 5) equals raw status AND the enable register.
- R7: Writing a word to the clear address 6 clears the latched edge status of each pin whose bit is 1; 0 bits have no effect; an edge arriving in the same cycle as its clear leaves the bit set.
- R8: The bank_irq output is 1 exactly when masked status is nonzero.
- R9: A pin change present at pin_in before a rising clock edge shows in raw status after the third rising edge (two synchronizer stages plus the status register).
- R10: After reset all registers read 0, so every pin is falling-edge, single-edge and masked; addresses 6 and 7 read 0; addresses 0 to 3 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Pin levels from the pads |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NPIN | Register write data |
| reg_rdata | output | NPIN | Register read data (combinational) |
| bank_irq | output | 1 | Bank interrupt, high while any masked status bit is set |

## Verification
The bench builds the block with NPIN = 8. At that width, one control word can put different pins in all five trigger modes at once. Random pin traffic then hits every mode while clears, enable changes and mode changes arrive in the same cycles as edges. The narrow width also keeps the top bit and the all-ones masks easy to reach in directed tests.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  output logic            bank_irq
);
  localparam logic [2:0] A_SENSE = 3'd0, A_BOTH = 3'd1, A_POL = 3'd2, A_EN = 3'd3,
                         A_RAW = 3'd4, A_MASK = 3'd5, A_CLR = 3'd6;

  logic [NPIN-1:0] s1, s2, s3;
  logic [NPIN-1:0] sense_q, both_q, pol_q, en_q, raw_q;
  logic [NPIN-1:0] rise, fall, edge_hit, lvl_hit, clr, masked;

  assign rise     = s2 & ~s3;
  assign fall     = ~s2 & s3;
  assign edge_hit = (both_q & (rise | fall)) | (~both_q & ((pol_q & rise) | (~pol_q & fall)));
  assign lvl_hit  = ~(pol_q ^ s2);
  assign clr      = (reg_we && reg_addr == A_CLR) ? reg_wdata : '0;
  assign masked   = raw_q & en_q;
  assign bank_irq = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_SENSE: sense_q <= reg_wdata;
        A_BOTH:  both_q  <= reg_wdata;
        A_POL:   pol_q   <= reg_wdata;
        A_EN:    en_q    <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else raw_q <= (sense_q & lvl_hit) | (~sense_q & (edge_hit | (raw_q & ~clr)));
  end

  always_comb begin
    case (reg_addr)
      A_SENSE: reg_rdata = sense_q;
      A_BOTH:  reg_rdata = both_q;
      A_POL:   reg_rdata = pol_q;
      A_EN:    reg_rdata = en_q;
      A_RAW:   reg_rdata = raw_q;
      A_MASK:  reg_rdata = masked;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic [NPIN-1:0] reg_wdata,
  input logic [NPIN-1:0] reg_rdata,
  input logic            bank_irq,
  input logic [NPIN-1:0] sense_q,
  input logic [NPIN-1:0] both_q,
  input logic [NPIN-1:0] pol_q,
  input logic [NPIN-1:0] en_q,
  input logic [NPIN-1:0] raw_q,
  input logic [NPIN-1:0] s2,
  input logic [NPIN-1:0] s3
);
  logic [NPIN-1:0] clr_w;
  assign clr_w = (reg_we && reg_addr == 3'd6) ? reg_wdata : '0;

  assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(sense_q)) == $past(sense_q & ~(pol_q ^ s2))));

  assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(sense_q) & ~$past(s2 ^ s3)) ==
              $past(raw_q & ~sense_q & ~(s2 ^ s3) & ~clr_w)));

  assert_both_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~sense_q & both_q & (s2 ^ s3)) & ~raw_q) == '0));

  assert_masked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd5) |-> ((reg_rdata & ~en_q) == '0));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq |-> (en_q != '0 && raw_q != '0));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPIN(NPIN)) u_chk (.*);

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin_in = '0, reg_wdata = '0, reg_rdata;
  logic reg_we = 0, bank_irq;
  logic [2:0] reg_addr = 3'd4;
  int checks = 0, errors = 0;
  string cur = "R10";

  always #4 clk = ~clk;

  gpio_irq_detect #(.NPIN(N)) i_gpio_irq_detect (.*);

  // behavioural reference
  bit m1[N], m2[N], m3[N], msen[N], mboth[N], mpol[N], men[N], mraw[N];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m1[i] = 0; m2[i] = 0; m3[i] = 0; msen[i] = 0;
        mboth[i] = 0; mpol[i] = 0; men[i] = 0; mraw[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        bit up, dn, hit, cl;
        up = m2[i] && !m3[i];
        dn = !m2[i] && m3[i];
        cl = reg_we && reg_addr == 3'd6 && reg_wdata[i];
        if (msen[i]) mraw[i] = (m2[i] == mpol[i]);
        else begin
          if (mboth[i]) hit = up || dn;
          else if (mpol[i]) hit = up;
          else hit = dn;
          if (hit) mraw[i] = 1;
          else if (cl) mraw[i] = 0;
        end
      end
      for (int i = 0; i < N; i++) begin
        if (reg_we) begin
          if (reg_addr == 0) msen[i] = reg_wdata[i];
          if (reg_addr == 1) mboth[i] = reg_wdata[i];
          if (reg_addr == 2) mpol[i] = reg_wdata[i];
          if (reg_addr == 3) men[i] = reg_wdata[i];
        end
        m3[i] = m2[i]; m2[i] = m1[i]; m1[i] = pin_in[i];
      end
    end
  end

  function automatic logic [N-1:0] exp_read(input logic [2:0] a);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++)
      case (a)
        3'd0: v[i] = msen[i];
        3'd1: v[i] = mboth[i];
        3'd2: v[i] = mpol[i];
        3'd3: v[i] = men[i];
        3'd4: v[i] = mraw[i];
        3'd5: v[i] = mraw[i] & men[i];
        default: v[i] = 0;
      endcase
    return v;
  endfunction

  task automatic tick();
    logic [N-1:0] e;
    @(negedge clk);
    e = exp_read(reg_addr);
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s: rdata at addr %0d actual %h expected %h", cur, reg_addr, reg_rdata, e);
    end
    checks++;
    if (bank_irq !== (exp_read(3'd5) != 0)) begin
      errors++;
      $display("FAIL R8 (%s): bank_irq actual %b expected %b", cur, bank_irq, exp_read(3'd5) != 0);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0; reg_addr = 3'd4;
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    reg_addr = a;
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur = "R10";
    for (int a = 0; a < 8; a++) idle(1, a[2:0]);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h0F); wr(3'd3, 8'hFF);
    for (int a = 0; a < 8; a++) idle(1, a[2:0]);
    idle(4, 3'd4);
    wr(3'd6, 8'hFF);

    cur = "R3";
    pin_in = 8'h00; idle(5, 3'd4);
    pin_in = 8'hFF; idle(5, 3'd4);
    wr(3'd6, 8'hFF);
    pin_in = 8'h00; idle(5, 3'd4);

    cur = "R7";
    wr(3'd6, 8'h00); idle(1, 3'd4);
    wr(3'd6, 8'h0C); idle(1, 3'd4);
    wr(3'd6, 8'hFF); idle(1, 3'd4);
    pin_in = 8'hFF; idle(2, 3'd4);
    wr(3'd6, 8'hFF); idle(2, 3'd4);

    cur = "R9";
    wr(3'd6, 8'hFF);
    pin_in = 8'h00; idle(4, 3'd4);
    wr(3'd6, 8'hFF);
    pin_in = 8'h01; idle(4, 3'd4);

    cur = "R2";
    wr(3'd1, 8'hF0); wr(3'd6, 8'hFF);
    pin_in = 8'h0F; idle(4, 3'd4);
    wr(3'd6, 8'hFF); pin_in = 8'hF0; idle(4, 3'd4);

    cur = "R4";
    wr(3'd0, 8'h3C); wr(3'd2, 8'h14);
    pin_in = 8'h00; idle(4, 3'd4);
    wr(3'd6, 8'hFF); idle(2, 3'd4);
    pin_in = 8'hFF; idle(4, 3'd4);

    cur = "R1";
    wr(3'd0, 8'h00); idle(3, 3'd4);
    wr(3'd0, 8'hFF); idle(3, 3'd4);

    cur = "R5";
    wr(3'd3, 8'h00); idle(3, 3'd4);
    cur = "R6";
    wr(3'd3, 8'h81); idle(3, 3'd5);
    pin_in = 8'h7E; idle(3, 3'd5);
    pin_in = 8'h81; idle(3, 3'd5);

    cur = "R1";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) pin_in = N'($urandom);
      if ($urandom_range(0, 4) == 0) begin
        reg_we = 1; reg_addr = 3'($urandom_range(0, 7)); reg_wdata = N'($urandom);
      end else begin
        reg_we = 0; reg_addr = 3'($urandom_range(0, 7));
      end
      tick();
    end
    reg_we = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule